// File: doc/BRIEF.md
# Host Mailbox Register Window

This block sits behind a bus target that has already decoded a 16-byte window and turns it into a two-way mailbox between a host and an embedded controller. Every byte the host writes, whatever its offset, is queued together with that offset in a small FIFO. The controller drains the FIFO through a pop port and decides what each byte means.

In the other direction the controller posts a data byte and a 3-bit type code. Posting raises an interrupt toward the host. The host reads the byte at offset 0, and that read drops the interrupt. Offset 1 returns a status byte. The status byte holds an active-low "data waiting" flag, a "queue full" flag and the type code. Writes to offset 2 also drive two serial-memory pins directly, so the host can bit-bang a configuration memory.

Top module: `hmbx_window`

## Requirements
- R1: After reset, irq is 0, ctl_pop_valid is 0, ovf_flag is 0, both serial pins are 1, offset 0 reads 0x00 and offset 1 reads 0x80.
- R2: A host write at any offset 0 to 15 queues the pair {offset, data}. The controller sees the entries in arrival order on ctl_pop_off/ctl_pop_data while ctl_pop_valid is 1. A pop removes the head.
- R3: The queue holds FIFO_DEPTH entries. While it is full, status bit 6 reads 1, otherwise 0. A host write while full is discarded and sets ovf_flag, which then stays 1 until reset.
- R4: A controller post makes irq 1 from the next cycle. Offset 0 then reads the posted byte. Status bit 7 reads 0 and status bits 5:3 read the posted type code.
- R5: A host read at offset 0 returns the data byte and clears irq from the next cycle. Afterwards status bit 7 reads 1 and the byte stays readable.
- R6: A post while data is still waiting replaces the byte and the type code, and irq stays 1.
- R7: When a post and a host read of offset 0 fall in the same cycle, the post wins: irq stays 1 and the new byte is held.
- R8: A host write at offset 2 sets ser_clk to data bit 0 and ser_dat to data bit 1 from the next cycle, and the write is still queued. Writes at other offsets leave the pins unchanged.
- R9: Host reads at offsets 2 to 15 return 0x00, and status bits 2:0 always read 0.
- R10: A pop while the queue is empty has no effect.
- R11: A host read of the status byte does not change irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host byte write strobe |
| host_rd | input | 1 | Host byte read strobe |
| host_off | input | 4 | Byte offset inside the window |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Read byte, valid in the cycle of host_rd |
| ctl_pop | input | 1 | Controller removes the queue head |
| ctl_pop_valid | output | 1 | Queue holds at least one entry |
| ctl_pop_off | output | 4 | Offset of the queue head |
| ctl_pop_data | output | 8 | Data of the queue head |
| ctl_post | input | 1 | Controller posts a byte to the host |
| ctl_post_data | input | 8 | Posted byte |
| ctl_post_type | input | 3 | Posted type code |
| irq | output | 1 | Interrupt to the host, high while posted data waits |
| ovf_flag | output | 1 | Sticky flag, set when a host write was discarded |
| ser_clk | output | 1 | Serial-memory clock pin |
| ser_dat | output | 1 | Serial-memory data pin |

## Verification
The bench builds the block with its default FIFO_DEPTH of 4. With that depth, four writes fill the queue, so the full flag and the discard path can be reached many times. This lets the bench sweep all sixteen offsets in four full-queue rounds and check every entry's offset and data. All eight type codes are posted, and each expected status byte is computed from the pending flag, the full flag and the code. The same small depth keeps the offset-2 pin path, empty pops and the same-cycle post/read race within a few dozen cycles.

// File: rtl/hmbx_pkg.sv
package hmbx_pkg;

    localparam int OFS_W  = 4;
    localparam int BYTE_W = 8;
    localparam int KIND_W = 3;

    typedef logic [OFS_W-1:0]  ofs_t;
    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [KIND_W-1:0] kind_t;

    // one queued host write
    typedef struct packed {
        ofs_t  ofs;
        byte_t data;
    } hmsg_t;

    // offsets with a read or side-effect meaning
    localparam ofs_t OFS_DATA = 4'd0;
    localparam ofs_t OFS_STAT = 4'd1;
    localparam ofs_t OFS_PINS = 4'd2;

    // bit positions inside an offset-2 write
    localparam int PIN_CLK_BIT = 0;
    localparam int PIN_DAT_BIT = 1;

    // status byte: [7] no data waiting, [6] queue full, [5:3] type, [2:0] zero
    function automatic byte_t pack_status(logic pending, logic full, kind_t kind);
        return {~pending, full, kind, 3'b000};
    endfunction

endpackage

// File: rtl/hmbx_fifo.sv
module hmbx_fifo
    import hmbx_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  push,
    input  hmsg_t din,
    input  logic  pop,
    output hmsg_t dout,
    output logic  not_empty,
    output logic  full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    hmsg_t          slot [DEPTH];
    logic [AW-1:0]  wr_ptr, rd_ptr;
    logic [CW-1:0]  count;
    logic           do_push, do_pop;

    assign full      = (count == CW'(DEPTH));
    assign not_empty = (count != '0);
    assign do_push   = push && !full;
    assign do_pop    = pop && not_empty;
    assign dout      = slot[rd_ptr];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                slot[g] <= '0;
            else if (do_push && wr_ptr == AW'(g))
                slot[g] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push)
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/hmbx_reply.sv
module hmbx_reply
    import hmbx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  post,
    input  byte_t post_data,
    input  kind_t post_kind,
    input  logic  host_take,
    output byte_t data_q,
    output kind_t kind_q,
    output logic  pending
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data_q  <= '0;
            kind_q  <= '0;
            pending <= 1'b0;
        end else if (post) begin
            // a fresh post outranks a concurrent host read
            data_q  <= post_data;
            kind_q  <= post_kind;
            pending <= 1'b1;
        end else if (host_take) begin
            pending <= 1'b0;
        end
    end

endmodule

// File: rtl/hmbx_pins.sv
module hmbx_pins
    import hmbx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  byte_t value,
    output logic  pin_clk,
    output logic  pin_dat
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pin_clk <= 1'b1;
            pin_dat <= 1'b1;
        end else if (load) begin
            pin_clk <= value[PIN_CLK_BIT];
            pin_dat <= value[PIN_DAT_BIT];
        end
    end

endmodule

// File: rtl/hmbx_window.sv
module hmbx_window
    import hmbx_pkg::*;
#(
    parameter int FIFO_DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       host_wr,
    input  logic       host_rd,
    input  logic [3:0] host_off,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    input  logic       ctl_pop,
    output logic       ctl_pop_valid,
    output logic [3:0] ctl_pop_off,
    output logic [7:0] ctl_pop_data,
    input  logic       ctl_post,
    input  logic [7:0] ctl_post_data,
    input  logic [2:0] ctl_post_type,
    output logic       irq,
    output logic       ovf_flag,
    output logic       ser_clk,
    output logic       ser_dat
);
    hmsg_t in_msg, head_msg;
    logic  fifo_full, fifo_ne;
    byte_t reply_data;
    kind_t reply_kind;
    logic  reply_pending;
    logic  ovf_q;
    logic  take_data;

    assign in_msg    = '{ofs: host_off, data: host_wdata};
    assign take_data = host_rd && (host_off == OFS_DATA);

    hmbx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (host_wr),
        .din       (in_msg),
        .pop       (ctl_pop),
        .dout      (head_msg),
        .not_empty (fifo_ne),
        .full      (fifo_full)
    );

    hmbx_reply u_reply (
        .clk       (clk),
        .rst       (rst),
        .post      (ctl_post),
        .post_data (ctl_post_data),
        .post_kind (ctl_post_type),
        .host_take (take_data),
        .data_q    (reply_data),
        .kind_q    (reply_kind),
        .pending   (reply_pending)
    );

    hmbx_pins u_pins (
        .clk     (clk),
        .rst     (rst),
        .load    (host_wr && (host_off == OFS_PINS)),
        .value   (host_wdata),
        .pin_clk (ser_clk),
        .pin_dat (ser_dat)
    );

    always_ff @(posedge clk) begin
        if (rst)
            ovf_q <= 1'b0;
        else if (host_wr && fifo_full)
            ovf_q <= 1'b1;
    end

    always_comb begin
        host_rdata = '0;
        if (host_rd) begin
            case (host_off)
                OFS_DATA: host_rdata = reply_data;
                OFS_STAT: host_rdata = pack_status(reply_pending, fifo_full, reply_kind);
                default:  host_rdata = '0;
            endcase
        end
    end

    assign ctl_pop_valid = fifo_ne;
    assign ctl_pop_off   = head_msg.ofs;
    assign ctl_pop_data  = head_msg.data;
    assign irq           = reply_pending;
    assign ovf_flag      = ovf_q;

endmodule

// File: rtl/hmbx_window_chk.sv
module hmbx_window_chk (
    input logic       clk,
    input logic       rst,
    input logic       host_wr,
    input logic       host_rd,
    input logic [3:0] host_off,
    input logic [7:0] host_wdata,
    input logic [7:0] host_rdata,
    input logic       ctl_pop_valid,
    input logic       ctl_post,
    input logic       irq,
    input logic       ovf_flag,
    input logic       ser_clk,
    input logic       ser_dat,
    input logic       fifo_full
);
    a_r2_write_leaves_entry: assert property (@(posedge clk) disable iff (rst)
        host_wr |=> ctl_pop_valid);

    a_r3_full_write_sets_ovf: assert property (@(posedge clk) disable iff (rst)
        (host_wr && fifo_full) |=> ovf_flag);

    a_r3_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        ovf_flag |=> ovf_flag);

    a_r4_post_raises_irq: assert property (@(posedge clk) disable iff (rst)
        ctl_post |=> irq);

    a_r5_read_clears_irq: assert property (@(posedge clk) disable iff (rst)
        (host_rd && host_off == 4'd0 && !ctl_post) |=> !irq);

    a_r11_irq_holds: assert property (@(posedge clk) disable iff (rst)
        (!ctl_post && !(host_rd && host_off == 4'd0)) |=> $stable(irq));

    a_r8_pins_follow: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_off == 4'd2) |=>
            (ser_clk == $past(host_wdata[0]) && ser_dat == $past(host_wdata[1])));

    a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (host_rd && host_off > 4'd1) |-> host_rdata == 8'h00);

    a_r9_status_low_zero: assert property (@(posedge clk) disable iff (rst)
        (host_rd && host_off == 4'd1) |-> host_rdata[2:0] == 3'b000);

endmodule

bind hmbx_window hmbx_window_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .host_wr       (host_wr),
    .host_rd       (host_rd),
    .host_off      (host_off),
    .host_wdata    (host_wdata),
    .host_rdata    (host_rdata),
    .ctl_pop_valid (ctl_pop_valid),
    .ctl_post      (ctl_post),
    .irq           (irq),
    .ovf_flag      (ovf_flag),
    .ser_clk       (ser_clk),
    .ser_dat       (ser_dat),
    .fifo_full     (fifo_full)
);

// File: tb/test_hmbx_window.sv
module test_hmbx_window;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_wr = 1'b0, host_rd = 1'b0;
    logic [3:0] host_off = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       ctl_pop = 1'b0;
    logic       ctl_pop_valid;
    logic [3:0] ctl_pop_off;
    logic [7:0] ctl_pop_data;
    logic       ctl_post = 1'b0;
    logic [7:0] ctl_post_data = '0;
    logic [2:0] ctl_post_type = '0;
    logic       irq, ovf_flag, ser_clk, ser_dat;

    int checks = 0;
    int failures = 0;
    logic [7:0] rv;

    always #(CLK_PERIOD/2) clk = ~clk;

    hmbx_window #(.FIFO_DEPTH(DEPTH)) i_hmbx_window (
        .clk(clk), .rst(rst),
        .host_wr(host_wr), .host_rd(host_rd), .host_off(host_off),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .ctl_pop(ctl_pop), .ctl_pop_valid(ctl_pop_valid),
        .ctl_pop_off(ctl_pop_off), .ctl_pop_data(ctl_pop_data),
        .ctl_post(ctl_post), .ctl_post_data(ctl_post_data),
        .ctl_post_type(ctl_post_type),
        .irq(irq), .ovf_flag(ovf_flag), .ser_clk(ser_clk), .ser_dat(ser_dat)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [3:0] off, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_off = off; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(input logic [3:0] off, output logic [7:0] d);
        @(negedge clk);
        host_rd = 1'b1; host_off = off;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic post(input logic [7:0] d, input logic [2:0] k);
        @(negedge clk);
        ctl_post = 1'b1; ctl_post_data = d; ctl_post_type = k;
        @(negedge clk);
        ctl_post = 1'b0;
    endtask

    task automatic pop_check(input logic [3:0] off, input logic [7:0] d, input string req);
        @(negedge clk);
        check(ctl_pop_valid, 1, req);
        check(ctl_pop_off, off, req);
        check(ctl_pop_data, d, req);
        ctl_pop = 1'b1;
        @(negedge clk);
        ctl_pop = 1'b0;
    endtask

    function automatic logic [7:0] pat(input int off);
        return 8'((off * 17) ^ 8'h5A);
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        @(negedge clk);
        check(irq, 0, "R1 irq");
        check(ctl_pop_valid, 0, "R1 pop_valid");
        check(ovf_flag, 0, "R1 ovf");
        check({ser_dat, ser_clk}, 2'b11, "R1 pins");
        host_read(4'd0, rv); check(rv, 8'h00, "R1 data");
        host_read(4'd1, rv); check(rv, 8'h80, "R1 status");

        // R9: unmapped offsets read zero
        for (int o = 2; o < 16; o++) begin
            host_read(4'(o), rv); check(rv, 8'h00, "R9 unmapped read");
        end

        // R2/R3: sweep all offsets in full-queue rounds
        for (int b = 0; b < 16; b += DEPTH) begin
            for (int i = 0; i < DEPTH; i++) host_write(4'(b + i), pat(b + i));
            host_read(4'd1, rv); check(rv[6], 1, "R3 full bit");
            for (int i = 0; i < DEPTH; i++) pop_check(4'(b + i), pat(b + i), "R2 entry");
            host_read(4'd1, rv); check(rv, 8'h80, "R3 not full");
        end
        check(ovf_flag, 0, "R3 no ovf yet");

        // R3: overflow drop and sticky flag
        for (int i = 0; i < DEPTH; i++) host_write(4'(i + 4), 8'(8'hA0 + i));
        host_write(4'd7, 8'hEE);
        check(ovf_flag, 1, "R3 ovf set");
        for (int i = 0; i < DEPTH; i++) pop_check(4'(i + 4), 8'(8'hA0 + i), "R3 kept entry");
        @(negedge clk);
        check(ctl_pop_valid, 0, "R3 dropped write absent");
        check(ovf_flag, 1, "R3 ovf sticky");

        // R10: pop while empty
        @(negedge clk); ctl_pop = 1'b1;
        @(negedge clk); ctl_pop = 1'b0;
        check(ctl_pop_valid, 0, "R10 still empty");
        host_write(4'd9, 8'h3C);
        pop_check(4'd9, 8'h3C, "R10 order after empty pop");
        @(negedge clk);
        check(ctl_pop_valid, 0, "R10 empty after one");

        // R8: offset-2 pin control
        host_write(4'd2, 8'h01); check({ser_dat, ser_clk}, 2'b01, "R8 clk=1 dat=0");
        host_write(4'd2, 8'h02); check({ser_dat, ser_clk}, 2'b10, "R8 clk=0 dat=1");
        host_write(4'd3, 8'h03); check({ser_dat, ser_clk}, 2'b10, "R8 other offset ignored");
        host_write(4'd2, 8'hFC); check({ser_dat, ser_clk}, 2'b00, "R8 both low");
        pop_check(4'd2, 8'h01, "R8 queued");
        pop_check(4'd2, 8'h02, "R8 queued");
        pop_check(4'd3, 8'h03, "R8 queued");
        pop_check(4'd2, 8'hFC, "R8 queued");

        // R4/R5/R11: sweep all type codes
        for (int k = 0; k < 8; k++) begin
            post(8'(8'h30 + k), 3'(k));
            check(irq, 1, "R4 irq");
            host_read(4'd1, rv); check(rv, 8'(k << 3), "R4 status");
            check(irq, 1, "R11 status read keeps irq");
            host_read(4'd0, rv); check(rv, 8'(8'h30 + k), "R4 data");
            check(irq, 0, "R5 irq cleared");
            host_read(4'd1, rv); check(rv, 8'(8'h80 | (k << 3)), "R5 status after read");
            host_read(4'd0, rv); check(rv, 8'(8'h30 + k), "R5 data kept");
        end

        // R6: overwrite while pending
        post(8'h11, 3'd1);
        post(8'h22, 3'd5);
        check(irq, 1, "R6 irq stays");
        host_read(4'd1, rv); check(rv, 8'h28, "R6 status new type");
        host_read(4'd0, rv); check(rv, 8'h22, "R6 data replaced");

        // R7: post and data read in the same cycle
        @(negedge clk);
        host_rd = 1'b1; host_off = 4'd0;
        ctl_post = 1'b1; ctl_post_data = 8'h77; ctl_post_type = 3'd2;
        @(negedge clk);
        host_rd = 1'b0; ctl_post = 1'b0;
        check(irq, 1, "R7 post wins");
        host_read(4'd0, rv); check(rv, 8'h77, "R7 new data");
        check(irq, 0, "R7 later read clears");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule